// File: doc/BRIEF.md
# Ring Quantization Noise Canceller

This block sits between the ring-oscillator phase logic of a digital fractional-N synthesizer and its loop filter. Once per reference period it receives a coarse phase sample `y` in the range −2 to +2. It also receives a snapshot of the thirteen inverter outputs of the ring, captured at the reference edge. From that snapshot it works out where the ring edge stood inside one oscillator cycle, as one of 26 sub-cycle phases. That phase is the fine error estimate ê.

The output uses a fixed-point scale in which one coarse step equals 26 LSBs. Each strobe produces `26·y − ê[n] + 2·ê[n−1] − ê[n−2]`. The second-difference term removes most of the second-order shaped quantization error before the sample reaches the loop filter. When cancellation is disabled, only `26·y` is passed on, and the estimate history keeps tracking the ring. A snapshot that is not a legal ring state is flagged. For such a snapshot the previous estimate is reused.

Top module: `ring_qnc`

## Requirements
- R1: After reset, `corr_valid` is 0, `corr_out` is 0 and `snap_bad` is 0. Both history terms ê[n−1] and ê[n−2] are zero, so the first strobe yields `26·y − ê[n]`.
- R2: The snapshot is normalised by inverting every odd-indexed stage (bit i for odd i). In that normalised word, phase p in 0..12 is the word whose low p bits are 1 and the rest 0. Phase p in 13..25 is the word whose low p−13 bits are 0 and the rest 1. These are the only legal snapshots, and ê equals p in output LSBs.
- R3: With `cancel_en` high, the output for a strobe is `26·y − ê[n] + 2·ê[n−1] − ê[n−2]` in two's complement.
- R4: `corr_out` and `snap_bad` are registered. They update in the cycle after a `sample_valid` strobe, and `corr_valid` is high exactly in that cycle. Without a strobe, `corr_out` holds its value.
- R5: An illegal snapshot raises `snap_bad` with its result, and that strobe uses ê[n] = ê[n−1].
- R6: With `cancel_en` low, the output is `26·y`. The history still takes in the estimate from that strobe.
- R7: The history shifts only on `sample_valid` strobes. Idle cycles between strobes leave ê[n−1] and ê[n−2] unchanged.
- R8: For inputs in range, the output stays within ±102 (26·2 + 2·25).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | One-cycle strobe per reference period |
| cancel_en | input | 1 | Enables the second-difference correction |
| ring_snap | input | 13 | Captured inverter stage outputs, bit i = stage i |
| coarse_y | input | 3 | Signed coarse sample, −2..+2 |
| corr_valid | output | 1 | High in the cycle after a strobe |
| corr_out | output | 8 | Signed corrected sample, 26 LSBs per coarse step |
| snap_bad | output | 1 | The strobe's snapshot was not a legal ring state |

## Verification
The bench builds the block with its defaults: 13 stages, a 3-bit coarse input and a coarse limit of 2. These values make all 26 phase codes and both ends of the ±102 output range reachable in a handful of strobes. Short hand-computed sequences then reach each history combination of interest. These include a wrap from phase 25 back to 0, a disabled strobe that still feeds the history, an illegal snapshot that repeats the last estimate, and idle gaps that must not shift the history.

// File: rtl/ring_qnc_pkg.sv
package ring_qnc_pkg;
  localparam int DEF_STAGES = 13;
  localparam int DEF_Y_W    = 3;
  localparam int DEF_Y_MAX  = 2;
endpackage

// File: rtl/ring_phase_decoder.sv
module ring_phase_decoder #(
  parameter int NSTAGE = ring_qnc_pkg::DEF_STAGES,
  localparam int PHASES = 2 * NSTAGE,
  localparam int PW = $clog2(PHASES)
) (
  input  logic [NSTAGE-1:0] snap,
  output logic [PW-1:0]     phase,
  output logic              ok
);
  logic [NSTAGE-1:0] norm;

  // undo the inversion of every odd stage
  for (genvar i = 0; i < NSTAGE; i++) begin : g_norm
    if (i % 2 == 1) begin : g_inv
      assign norm[i] = ~snap[i];
    end else begin : g_pass
      assign norm[i] = snap[i];
    end
  end

  function automatic logic [NSTAGE-1:0] low_ones(input int k);
    logic [NSTAGE-1:0] m;
    m = '0;
    for (int j = 0; j < NSTAGE; j++) m[j] = (j < k);
    return m;
  endfunction

  int ones;
  always_comb begin
    ones = 0;
    for (int j = 0; j < NSTAGE; j++) ones += int'(norm[j]);
    if (!norm[NSTAGE-1]) begin
      phase = PW'(ones);
      ok    = (norm == low_ones(ones));
    end else begin
      phase = PW'(PHASES - ones);
      ok    = (norm == ~low_ones(NSTAGE - ones));
    end
  end
endmodule

// File: rtl/qnc_history.sv
module qnc_history #(
  parameter int EW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [EW-1:0] e_new,
  output logic [EW-1:0] e_d1,
  output logic [EW-1:0] e_d2
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_d1 <= '0;
      e_d2 <= '0;
    end else if (adv) begin
      e_d1 <= e_new;
      e_d2 <= e_d1;
    end
  end
endmodule

// File: rtl/qnc_combiner.sv
module qnc_combiner #(
  parameter int EW = 5,
  parameter int Y_W = 3,
  parameter int STEP = 26,
  parameter int OUT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    strobe,
  input  logic                    en,
  input  logic                    bad,
  input  logic signed [Y_W-1:0]   y,
  input  logic [EW-1:0]           e0,
  input  logic [EW-1:0]           e1,
  input  logic [EW-1:0]           e2,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_val,
  output logic                    out_bad
);
  function automatic logic signed [OUT_W-1:0] widen(input logic [EW-1:0] e);
    return OUT_W'($signed({1'b0, e}));
  endfunction

  function automatic logic signed [OUT_W-1:0] scale_coarse(input logic signed [Y_W-1:0] v);
    return OUT_W'(v) * OUT_W'(STEP);
  endfunction

  function automatic logic signed [OUT_W-1:0] second_diff(
    input logic [EW-1:0] a, input logic [EW-1:0] b, input logic [EW-1:0] c);
    return (widen(b) <<< 1) - widen(a) - widen(c);
  endfunction

  logic signed [OUT_W-1:0] coarse_scaled;
  logic signed [OUT_W-1:0] shaped;
  assign coarse_scaled = scale_coarse(y);
  assign shaped        = second_diff(e0, e1, e2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_val   <= '0;
      out_bad   <= 1'b0;
    end else begin
      out_valid <= strobe;
      if (strobe) begin
        out_val <= en ? coarse_scaled + shaped : coarse_scaled;
        out_bad <= bad;
      end
    end
  end
endmodule

// File: rtl/ring_qnc.sv
module ring_qnc #(
  parameter int NSTAGE = ring_qnc_pkg::DEF_STAGES,
  parameter int Y_W    = ring_qnc_pkg::DEF_Y_W,
  parameter int Y_MAX  = ring_qnc_pkg::DEF_Y_MAX,
  localparam int PHASES = 2 * NSTAGE,
  localparam int PW     = $clog2(PHASES),
  localparam int OUT_W  = $clog2(PHASES * Y_MAX + 2 * (PHASES - 1) + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sample_valid,
  input  logic                    cancel_en,
  input  logic [NSTAGE-1:0]       ring_snap,
  input  logic signed [Y_W-1:0]   coarse_y,
  output logic                    corr_valid,
  output logic signed [OUT_W-1:0] corr_out,
  output logic                    snap_bad
);
  logic [PW-1:0] phase_code;
  logic          phase_ok;
  logic [PW-1:0] est_now;
  logic [PW-1:0] est_d1;
  logic [PW-1:0] est_d2;

  ring_phase_decoder #(.NSTAGE(NSTAGE)) u_dec (
    .snap(ring_snap), .phase(phase_code), .ok(phase_ok)
  );

  // an illegal snapshot repeats the last estimate
  assign est_now = phase_ok ? phase_code : est_d1;

  qnc_history #(.EW(PW)) u_hist (
    .clk(clk), .rst_n(rst_n), .adv(sample_valid),
    .e_new(est_now), .e_d1(est_d1), .e_d2(est_d2)
  );

  qnc_combiner #(.EW(PW), .Y_W(Y_W), .STEP(PHASES), .OUT_W(OUT_W)) u_comb (
    .clk(clk), .rst_n(rst_n), .strobe(sample_valid), .en(cancel_en),
    .bad(!phase_ok), .y(coarse_y), .e0(est_now), .e1(est_d1), .e2(est_d2),
    .out_valid(corr_valid), .out_val(corr_out), .out_bad(snap_bad)
  );
endmodule

// File: rtl/ring_qnc_checker.sv
module ring_qnc_checker #(
  parameter int NSTAGE = 13,
  parameter int Y_W = 3,
  parameter int Y_MAX = 2,
  parameter int PW = 5,
  parameter int OUT_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sample_valid,
  input logic                    cancel_en,
  input logic signed [Y_W-1:0]   coarse_y,
  input logic                    corr_valid,
  input logic signed [OUT_W-1:0] corr_out,
  input logic                    snap_bad,
  input logic [PW-1:0]           phase_code,
  input logic                    phase_ok
);
  localparam int PHASES = 2 * NSTAGE;
  localparam int BOUND  = PHASES * Y_MAX + 2 * (PHASES - 1);

  assert_strobe_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> corr_valid);
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> (!corr_valid && $stable(corr_out)));
  assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_ok |-> (int'(phase_code) < PHASES));
  assert_bad_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && !phase_ok) |=> snap_bad);
  assert_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && !cancel_en) |=>
      (corr_out == OUT_W'($past(coarse_y)) * OUT_W'(PHASES)));
  assert_out_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(corr_out) <= BOUND) && (int'(corr_out) >= -BOUND));
endmodule

bind ring_qnc ring_qnc_checker #(
  .NSTAGE(NSTAGE), .Y_W(Y_W), .Y_MAX(Y_MAX), .PW(PW), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .cancel_en(cancel_en),
  .coarse_y(coarse_y), .corr_valid(corr_valid), .corr_out(corr_out),
  .snap_bad(snap_bad), .phase_code(phase_code), .phase_ok(phase_ok)
);

// File: tb/tb_ring_qnc.sv
module tb_ring_qnc;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sample_valid = 1'b0;
  logic              cancel_en = 1'b1;
  logic [12:0]       ring_snap = '0;
  logic signed [2:0] coarse_y = '0;
  logic              corr_valid;
  logic signed [7:0] corr_out;
  logic              snap_bad;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ring_qnc dut (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .cancel_en(cancel_en),
    .ring_snap(ring_snap), .coarse_y(coarse_y), .corr_valid(corr_valid),
    .corr_out(corr_out), .snap_bad(snap_bad)
  );

  // {cancel_en, y, phase, expected}
  localparam logic [16:0] VEC [10] = '{
    {1'b1, 3'(0),  5'd5,  8'(-5)},
    {1'b1, 3'(1),  5'd10, 8'(26)},
    {1'b1, 3'(-2), 5'd25, 8'(-62)},
    {1'b1, 3'(2),  5'd0,  8'(92)},
    {1'b1, 3'(-1), 5'd13, 8'(-64)},
    {1'b0, 3'(2),  5'd7,  8'(52)},
    {1'b1, 3'(0),  5'd7,  8'(-6)},
    {1'b1, 3'(0),  5'd7,  8'(0)},
    {1'b1, 3'(-1), 5'd20, 8'(-39)},
    {1'b1, 3'(1),  5'd12, 8'(47)}
  };

  function automatic logic [12:0] ring_of(input int p);
    logic [12:0] w;
    for (int k = 0; k < 13; k++)
      w[k] = (p < 13) ? (k < p) : (k >= p - 13);
    return w ^ 13'h0AAA;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(input bit en, input logic signed [2:0] y, input logic [12:0] s);
    @(negedge clk);
    cancel_en = en; coarse_y = y; ring_snap = s; sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", int'(corr_valid), 0);
    check("R1 out", int'(corr_out), 0);
    check("R1 bad", int'(snap_bad), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 10; i++) begin
      strobe(VEC[i][16], 3'(VEC[i][15:13]), ring_of(int'(VEC[i][12:8])));
      check(VEC[i][16] ? "R3 R2 vector" : "R6 bypass vector", int'(corr_out), int'($signed(VEC[i][7:0])));
      check("R4 valid", int'(corr_valid), 1);
    end

    // R5: illegal pattern, history e1=12 e2=20 -> -12+24-20
    strobe(1'b1, 3'(0), 13'b0000000000101 ^ 13'h0AAA);
    check("R5 hold", int'(corr_out), -8);
    check("R5 flag", int'(snap_bad), 1);
    repeat (3) @(negedge clk);
    check("R4 idle valid", int'(corr_valid), 0);
    check("R4 idle hold", int'(corr_out), -8);
    // R7: history still e1=12 e2=12
    strobe(1'b1, 3'(0), ring_of(12));
    check("R7 no shift", int'(corr_out), 0);
    check("R5 flag clear", int'(snap_bad), 0);

    // R8 extremes
    strobe(1'b1, 3'(0), ring_of(0));
    strobe(1'b1, 3'(0), ring_of(25));
    strobe(1'b1, 3'(2), ring_of(0));
    check("R8 max", int'(corr_out), 102);
    strobe(1'b1, 3'(-2), ring_of(25));
    check("R8 min", int'(corr_out), -102);

    // R1: reset clears history
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset out", int'(corr_out), 0);
    rst_n = 1'b1;
    strobe(1'b1, 3'(1), ring_of(3));
    check("R1 cleared history", int'(corr_out), 23);
    done = 1'b1;
  end

  initial begin
    for (int n = 0; n < 5000 && !done; n++) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule